// File: doc/BRIEF.md
# Sampling Converter Result Output Port

This block is the digital back end of a 16-bit sampling converter. An active-low start strobe begins a conversion. A busy flag then stays high for a fixed number of clock cycles, set by a parameter. When busy drops, the block captures a stand-in sample word from its `sampleIn` input. That word takes the place of the analog core's result.

The result leaves the block by one of two routes. In parallel mode the whole word is driven onto a tri-state bus. In serial master mode the block makes its own serial clock by dividing the system clock, together with a frame sync. It shifts the word out MSB first on bus line 0, and the other bus lines float. Chip-select and read are ORed, so the bus is released whenever either of them is high.

An input selects straight binary or two's complement coding. Two more inputs invert the serial clock and the sync. A read-mode input sets when the frame is sent: either the new result after the conversion ends, or the previous result while the next conversion is running. A result that finishes while a frame is still being sent is held back until that frame has completed.

Top module: `adc_result_port`

## Requirements
- R1: Whenever `csN` or `rdN` is high, every line of `dataBus` is released (high impedance), in both parallel and serial mode.
- R2: In parallel mode (`serialMode`=0) with `csN`=`rdN`=0, `dataBus` carries the current result. With `twosComp`=0 the word is sent unchanged (straight binary). With `twosComp`=1 bit 15 is inverted and bits 14..0 are unchanged.
- R3: `busy` rises at the first rising clock edge at which `convStartN` is sampled low after being sampled high. It stays high for exactly CONV_CYCLES cycles. `sampleIn` is captured as the new result at the edge where `busy` falls.
- R4: A high-to-low transition of `convStartN` while `busy` is high is ignored. It neither extends the current conversion nor starts another one.
- R5: In serial mode the active sync lasts exactly 16×CLK_DIV cycles. Within it the uninverted serial clock runs 16 periods of CLK_DIV cycles each: low for the first CLK_DIV/2 cycles of a period, high for the rest. Outside a frame the serial clock rests at its low (uninverted) level.
- R6: A serial frame sends the coded word MSB first on `dataBus[0]`. Each bit changes at the falling edge of the uninverted serial clock and is stable while that clock rises. During the frame `dataBus[15:1]` float, and the coding select of R2 applies to the serial word.
- R7: With `rdDuringConv`=0, a frame starts on the same clock edge at which `busy` falls, and it carries the new result.
- R8: With `rdDuringConv`=1, a frame starts on the same clock edge at which `busy` rises, and it carries the result of the previous conversion.
- R9: `sclkInv`=1 inverts `sclkOut` and `syncInv`=1 inverts `syncOut`. With both at 0 the sync is active high.
- R10: A conversion that ends while a frame is in progress does not overwrite the result until the frame completes. With `rdDuringConv`=0, the held result is then sent in a frame that starts one cycle after the previous frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| convStartN | input | 1 | Active-low conversion start strobe |
| sampleIn | input | 16 | Stand-in conversion result, captured at end of conversion |
| serialMode | input | 1 | 1 = serial master output, 0 = parallel output |
| rdDuringConv | input | 1 | 1 = stream previous result during conversion, 0 = stream after conversion |
| twosComp | input | 1 | 1 = two's complement coding, 0 = straight binary |
| sclkInv | input | 1 | Inverts the generated serial clock |
| syncInv | input | 1 | Inverts the frame sync |
| csN | input | 1 | Active-low chip select |
| rdN | input | 1 | Active-low read enable |
| busy | output | 1 | High while a conversion is running |
| sclkOut | output | 1 | Generated serial clock |
| syncOut | output | 1 | Frame sync |
| dataBus | inout | 16 | Tri-state result bus; line 0 also carries serial data |

## Verification
On every cycle the assertions check four things: the bus release whenever chip-select or read is high, the exact busy width (which also catches a restart caused by an ignored strobe), the exact sync width with the clock at rest outside a frame, and that the serial bit holds steady across each rising clock edge. Only the bench scenarios can show the content of the data. That covers the coded parallel word for each coding, the serial word bit by bit, whether the frame carries the new or the previous result in each read mode, and the deferred result reaching a later frame or a later parallel read.

// File: rtl/adc_result_port_pkg.sv
package adc_result_port_pkg;

  // Strobes from the control FSM to the datapath, valid for one cycle.
  typedef struct packed {
    logic latchNew;     // capture sampleIn into the result register
    logic holdPending;  // capture sampleIn into the pending register
    logic loadPending;  // move pending word into the result register
    logic frameStart;   // load shifter, first bit goes out
    logic shiftBit;     // advance shifter by one bit
  } ctrlStrobes_t;

endpackage

// File: rtl/adc_result_port_ctrl.sv
module adc_result_port_ctrl
  import adc_result_port_pkg::*;
#(
  parameter int CONV_CYCLES = 20,
  parameter int CLK_DIV     = 4,
  parameter int DATA_W      = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         convStartN,
  input  logic         serialMode,
  input  logic         rdDuringConv,
  output logic         busy,
  output logic         frameActive,
  output logic         sclkRaw,
  output ctrlStrobes_t strobes
);

  localparam int CNT_W  = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam int DIV_W  = $clog2(CLK_DIV);
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int HALF   = CLK_DIV / 2;
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(CLK_DIV - 1);
  localparam logic [DIV_W-1:0] DIV_HALF  = DIV_W'(HALF);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(DATA_W - 1);

  logic             startPrevN;
  logic [CNT_W-1:0] convCnt;
  logic             pendValid;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;

  logic startEdge, startOk, convDone, frameReq, bitEnd, frameEnd;

  // Conversion start detection: high-to-low on the strobe, only while idle.
  assign startEdge = startPrevN & ~convStartN;
  assign startOk   = startEdge & ~busy;
  assign convDone  = busy & (convCnt == '0);

  // Result ownership: a finished conversion waits while a frame is out.
  always_comb begin
    strobes.latchNew    = convDone & ~frameActive;
    strobes.holdPending = convDone & frameActive;
    strobes.loadPending = pendValid & ~frameActive & ~convDone;
  end

  assign frameReq = serialMode &
                    (rdDuringConv ? startOk
                                  : (strobes.latchNew | strobes.loadPending));

  assign bitEnd   = frameActive & (divCnt == DIV_LAST);
  assign frameEnd = bitEnd & (bitCnt == BIT_LAST);

  always_comb begin
    strobes.frameStart = frameReq & ~frameActive;
    strobes.shiftBit   = bitEnd & (bitCnt != BIT_LAST);
  end

  assign sclkRaw = frameActive & (divCnt >= DIV_HALF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPrevN <= 1'b1;
      busy       <= 1'b0;
      convCnt    <= '0;
    end else begin
      startPrevN <= convStartN;
      if (startOk) begin
        busy    <= 1'b1;
        convCnt <= CONV_LAST;
      end else if (busy) begin
        if (convDone) busy <= 1'b0;
        else          convCnt <= convCnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
    end else if (strobes.holdPending) begin
      pendValid <= 1'b1;
    end else if (strobes.latchNew || strobes.loadPending) begin
      pendValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameActive <= 1'b0;
      divCnt      <= '0;
      bitCnt      <= '0;
    end else if (strobes.frameStart) begin
      frameActive <= 1'b1;
      divCnt      <= '0;
      bitCnt      <= '0;
    end else if (frameActive) begin
      if (bitEnd) begin
        divCnt <= '0;
        if (frameEnd) frameActive <= 1'b0;
        else          bitCnt <= bitCnt + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_result_port_dp.sv
module adc_result_port_dp
  import adc_result_port_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int SER_LANE = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              twosComp,
  input  logic              serialMode,
  input  logic              csN,
  input  logic              rdN,
  output logic [DATA_W-1:0] busVal,
  output logic [DATA_W-1:0] busEn
);

  logic [DATA_W-1:0] resultReg;
  logic [DATA_W-1:0] pendingReg;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] shiftSrc;
  logic [DATA_W-1:0] parWord;
  logic              selected;

  // Two's complement view differs from offset binary only in the MSB.
  function automatic logic [DATA_W-1:0] applyCoding(input logic [DATA_W-1:0] w,
                                                     input logic tc);
    return {w[DATA_W-1] ^ tc, w[DATA_W-2:0]};
  endfunction

  // A frame launched together with a capture must see the fresh word.
  always_comb begin
    if (strobes.latchNew)         shiftSrc = sampleIn;
    else if (strobes.loadPending) shiftSrc = pendingReg;
    else                          shiftSrc = resultReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultReg  <= '0;
      pendingReg <= '0;
      shiftReg   <= '0;
    end else begin
      if (strobes.latchNew)         resultReg <= sampleIn;
      else if (strobes.loadPending) resultReg <= pendingReg;

      if (strobes.holdPending) pendingReg <= sampleIn;

      if (strobes.frameStart)
        shiftReg <= applyCoding(shiftSrc, twosComp);
      else if (strobes.shiftBit)
        shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
    end
  end

  assign selected = ~(csN | rdN);
  assign parWord  = applyCoding(resultReg, twosComp);

  for (genvar lane = 0; lane < DATA_W; lane++) begin : g_lane
    if (lane == SER_LANE) begin : g_serLane
      assign busEn[lane]  = selected;
      assign busVal[lane] = serialMode ? shiftReg[DATA_W-1] : parWord[lane];
    end else begin : g_parLane
      assign busEn[lane]  = selected & ~serialMode;
      assign busVal[lane] = parWord[lane];
    end
  end

endmodule

// File: rtl/adc_result_port.sv
module adc_result_port
  import adc_result_port_pkg::*;
#(
  parameter int CONV_CYCLES = 20,
  parameter int CLK_DIV     = 4,
  parameter int DATA_W      = 16,
  parameter int SER_LANE    = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convStartN,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              serialMode,
  input  logic              rdDuringConv,
  input  logic              twosComp,
  input  logic              sclkInv,
  input  logic              syncInv,
  input  logic              csN,
  input  logic              rdN,
  output logic              busy,
  output logic              sclkOut,
  output logic              syncOut,
  inout  wire  [DATA_W-1:0] dataBus
);

  ctrlStrobes_t      strobes;
  logic              frameActive;
  logic              sclkRaw;
  logic [DATA_W-1:0] busVal;
  logic [DATA_W-1:0] busEn;

  adc_result_port_ctrl #(
    .CONV_CYCLES(CONV_CYCLES), .CLK_DIV(CLK_DIV), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .convStartN(convStartN),
    .serialMode(serialMode), .rdDuringConv(rdDuringConv),
    .busy(busy), .frameActive(frameActive), .sclkRaw(sclkRaw),
    .strobes(strobes)
  );

  adc_result_port_dp #(
    .DATA_W(DATA_W), .SER_LANE(SER_LANE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sampleIn(sampleIn),
    .twosComp(twosComp), .serialMode(serialMode), .csN(csN), .rdN(rdN),
    .busVal(busVal), .busEn(busEn)
  );

  assign sclkOut = sclkRaw ^ sclkInv;
  assign syncOut = frameActive ^ syncInv;

  for (genvar i = 0; i < DATA_W; i++) begin : g_drv
    assign dataBus[i] = busEn[i] ? busVal[i] : 1'bz;
  end

endmodule

// File: rtl/adc_result_port_checker.sv
module adc_result_port_checker #(
  parameter int CONV_CYCLES = 20,
  parameter int CLK_DIV     = 4,
  parameter int DATA_W      = 16,
  parameter int SER_LANE    = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              rdN,
  input logic              busy,
  input logic              sclkOut,
  input logic              syncOut,
  input logic              sclkInv,
  input logic              syncInv,
  input logic [DATA_W-1:0] busEn,
  input logic [DATA_W-1:0] busVal
);

  logic [31:0] busyRun;
  logic [31:0] syncRun;
  logic        syncActive;
  logic        sclkPlain;

  assign syncActive = syncOut ^ syncInv;
  assign sclkPlain  = sclkOut ^ sclkInv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyRun <= '0;
      syncRun <= '0;
    end else begin
      busyRun <= busy ? busyRun + 1 : '0;
      syncRun <= syncActive ? syncRun + 1 : '0;
    end
  end

  AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (csN || rdN) |-> (busEn == '0)); // R1

  AST_BUSY_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == 32'(CONV_CYCLES))); // R3

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun <= 32'(CONV_CYCLES))); // R4

  AST_SYNC_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(syncActive) |-> (syncRun == 32'(DATA_W * CLK_DIV))); // R5

  AST_SCLK_REST: assert property (@(posedge clk) disable iff (!rstN)
    !syncActive |-> (sclkPlain == 1'b0)); // R5

  AST_BIT_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (syncActive && $rose(sclkPlain)) |-> $stable(busVal[SER_LANE])); // R6

endmodule

bind adc_result_port adc_result_port_checker #(
  .CONV_CYCLES(CONV_CYCLES), .CLK_DIV(CLK_DIV),
  .DATA_W(DATA_W), .SER_LANE(SER_LANE)
) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .busy(busy),
  .sclkOut(sclkOut), .syncOut(syncOut), .sclkInv(sclkInv),
  .syncInv(syncInv), .busEn(busEn), .busVal(busVal)
);

// File: tb/adc_result_port_tb.sv
`timescale 1ns/1ps
module adc_result_port_tb;

  localparam int CONV = 20;
  localparam int DIV  = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        convStartN = 1'b1;
  logic [15:0] sampleIn = '0;
  logic        serialMode = 1'b0, rdDuringConv = 1'b0, twosComp = 1'b0;
  logic        sclkInv = 1'b0, syncInv = 1'b0, csN = 1'b1, rdN = 1'b1;
  logic        busy, sclkOut, syncOut;
  wire  [15:0] dataBus;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  // Pull-ups make a released line read as 1.
  for (genvar i = 0; i < 16; i++) begin : g_pu
    pullup (dataBus[i]);
  end

  adc_result_port u_dut (
    .clk(clk), .rstN(rstN), .convStartN(convStartN), .sampleIn(sampleIn),
    .serialMode(serialMode), .rdDuringConv(rdDuringConv), .twosComp(twosComp),
    .sclkInv(sclkInv), .syncInv(syncInv), .csN(csN), .rdN(rdN),
    .busy(busy), .sclkOut(sclkOut), .syncOut(syncOut), .dataBus(dataBus)
  );

  // {twosComp, sample, expected parallel word}
  localparam logic [32:0] VECS [0:5] = '{
    {1'b0, 16'h1234, 16'h1234},
    {1'b1, 16'h1234, 16'h9234},
    {1'b1, 16'h8000, 16'h0000},
    {1'b1, 16'h7FFF, 16'hFFFF},
    {1'b0, 16'hFFFF, 16'hFFFF},
    {1'b1, 16'h0000, 16'h8000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic startPulse();
    @(negedge clk) convStartN = 1'b0;
    @(negedge clk) convStartN = 1'b1;
  endtask

  task automatic measureConv(output int len);
    startPulse();
    len = 0;
    while (busy && len < 1000) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic captureFrame(output logic [15:0] word, output int syncLen,
                              output int sclkErr, output int laneErr);
    int guard = 0;
    word = '0; syncLen = 0; sclkErr = 0; laneErr = 0;
    while (!(syncOut ^ syncInv) && guard < 2000) begin
      guard++;
      @(negedge clk);
    end
    while ((syncOut ^ syncInv) && syncLen < 1000) begin
      if ((sclkOut ^ sclkInv) != ((syncLen % DIV) >= DIV / 2)) sclkErr++;
      if ((syncLen % DIV) == DIV / 2) word = {word[14:0], dataBus[0]};
      if (dataBus[15:1] !== 15'h7FFF) laneErr++;
      syncLen++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int len, sLen, sErr, lErr;
    logic [15:0] w;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Reset state
    chk("R3 reset busy", 32'(busy), 32'd0);
    chk("R9 reset sync", 32'(syncOut), 32'd0);
    chk("R5 reset sclk", 32'(sclkOut), 32'd0);
    chk("R1 reset bus released", 32'(dataBus), 32'hFFFF);
    csN = 1'b0; rdN = 1'b0;
    @(negedge clk);
    chk("R2 reset result", 32'(dataBus), 32'h0000);

    // R2/R3 table walk in parallel mode
    for (int v = 0; v < 6; v++) begin
      twosComp = VECS[v][32];
      sampleIn = VECS[v][31:16];
      measureConv(len);
      chk("R3 busy width", 32'(len), 32'(CONV));
      chk("R2 parallel word", 32'(dataBus), 32'(VECS[v][15:0]));
    end

    // R4: extra start strobe while busy is ignored
    twosComp = 1'b0;
    sampleIn = 16'h4321;
    startPulse();
    len = 0;
    while (busy && len < 1000) begin
      len++;
      if (len == 5) convStartN = 1'b0;
      if (len == 6) convStartN = 1'b1;
      @(negedge clk);
    end
    chk("R4 busy width with ignored strobe", 32'(len), 32'(CONV));
    repeat (3) @(negedge clk);
    chk("R4 no second conversion", 32'(busy), 32'd0);
    chk("R4 result", 32'(dataBus), 32'h4321);

    // R1: released bus for every cs/rd combination with one high
    sampleIn = 16'h0000;
    measureConv(len);
    for (int m = 0; m < 2; m++) begin
      serialMode = m[0];
      for (int c = 1; c < 4; c++) begin
        csN = c[0]; rdN = c[1];
        @(negedge clk);
        chk("R1 bus released", 32'(dataBus), 32'hFFFF);
      end
    end
    serialMode = 1'b0; csN = 1'b0; rdN = 1'b0;
    @(negedge clk);
    chk("R1 bus driven when selected", 32'(dataBus), 32'h0000);

    // R7: read after convert, straight binary
    serialMode = 1'b1; rdDuringConv = 1'b0;
    sampleIn = 16'hA5C3;
    startPulse();
    while (busy) @(negedge clk);
    chk("R7 sync with busy fall", 32'(syncOut), 32'd1);
    captureFrame(w, sLen, sErr, lErr);
    chk("R7 serial word", 32'(w), 32'hA5C3);
    chk("R5 sync length", 32'(sLen), 32'(16 * DIV));
    chk("R5 sclk shape", 32'(sErr), 32'd0);
    chk("R6 other lanes float", 32'(lErr), 32'd0);

    // R9: inverted polarities, two's complement serial word
    sclkInv = 1'b1; syncInv = 1'b1; twosComp = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 idle sclk inverted", 32'(sclkOut), 32'd1);
    chk("R9 idle sync inverted", 32'(syncOut), 32'd1);
    sampleIn = 16'h1E0F;
    startPulse();
    captureFrame(w, sLen, sErr, lErr);
    chk("R6 coded serial word", 32'(w), 32'h9E0F);
    chk("R9 sync length inverted", 32'(sLen), 32'(16 * DIV));
    chk("R9 sclk shape inverted", 32'(sErr), 32'd0);
    sclkInv = 1'b0; syncInv = 1'b0; twosComp = 1'b0;

    // R8 + R10: read during convert sends previous result
    rdDuringConv = 1'b1;
    repeat (2) @(negedge clk);
    sampleIn = 16'h5A5A;
    startPulse();
    chk("R8 busy at frame start", 32'(busy), 32'd1);
    chk("R8 sync with busy rise", 32'(syncOut), 32'd1);
    captureFrame(w, sLen, sErr, lErr);
    chk("R8 previous result streamed", 32'(w), 32'h1E0F);
    sampleIn = 16'hFFFF;
    repeat (2) @(negedge clk);
    serialMode = 1'b0;
    @(negedge clk);
    chk("R10 held result delivered", 32'(dataBus), 32'h5A5A);

    // R10: read after convert, second conversion ends mid-frame
    serialMode = 1'b1; rdDuringConv = 1'b0;
    sampleIn = 16'h0F0F;
    startPulse();
    fork
      captureFrame(w, sLen, sErr, lErr);
      begin
        while (!syncOut) @(negedge clk);
        repeat (10) @(negedge clk);
        sampleIn = 16'h3C3C;
        startPulse();
      end
    join
    chk("R10 first frame intact", 32'(w), 32'h0F0F);
    @(negedge clk);
    chk("R10 next frame follows", 32'(syncOut), 32'd1);
    captureFrame(w, sLen, sErr, lErr);
    chk("R10 deferred word sent", 32'(w), 32'h3C3C);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule